// File: doc/BRIEF.md
# SATA Register Frame Codec

This block sits between a host port's command fetch logic and its receive-area writer. On the inbound side it takes one 20-byte host-to-device register frame per `rx_valid` cycle, presented as a flat byte vector with byte 0 in bits 7:0. It classifies the frame and rejects anything that is not a register frame with a legal control byte. Plain commands are split into opcode, feature, block count and logical block address. Queued read and write commands go to a separate output carrying their tag and address. A two-state tracker follows the soft-reset bit of the device-control byte and asks for a port reset when that bit is released.

On the outbound side the block builds the 20-byte device-to-host register frame from the current device status and error bytes and the host's pending-interrupt flag. The frame echoes the address and count bytes of the most recent plain command, or carries the fixed power-up pattern when an initial frame is requested. Each delivered frame raises the register-frame interrupt cause. A task-file-error cause is also raised when the status reports an error. No frame and no cause is produced while frame reception is disabled. All outputs are registered and appear one cycle after the request.

Top module: `regfis_codec`

## Requirements
- R1: An inbound frame whose byte 0 is not 0x27 raises `frame_err` for one cycle, produces no command or queued output, and leaves the soft-reset tracker unchanged.
- R2: Byte 1 equal to 0x80 selects command decoding. Byte 1 equal to 0x00 is accepted without any command output. Any other byte 1 value raises `frame_err`.
- R3: For an accepted command frame that is not queued, `cmd_valid` pulses one cycle after `rx_valid`. It carries byte 2 as `cmd_opcode` and byte 3 as `cmd_feature`.
- R4: `cmd_count` is byte 13 (high) joined with byte 12 (low), except that a value of zero is reported as 256.
- R5: `cmd_lba` is the bitwise OR of two fields: bytes 10, 9, 8, 6, 5, 4 placed at bits 47:40 down to 7:0, and byte 7 bits 3:0 placed at bits 27:24.
- R6: Opcodes 0x60 (queued read) and 0x61 (queued write) pulse `q_valid` instead of `cmd_valid`. In that case `q_write` is set for 0x61, `q_tag` is byte 12 bits 7:3, and `q_lba` comes only from bytes 10, 9, 8, 6, 5, 4, so byte 7 has no effect.
- R7: The tracker uses byte 15 bit 2 of every accepted frame. While running, a set bit moves it to the held state. While held, a clear bit returns it to running and pulses `port_rst` one cycle after `rx_valid`.
- R8: An outbound frame has byte 0 = 0x34, byte 1 bit 6 = `host_irq_pend`, byte 2 = `dev_status`, byte 3 = `dev_error`, and bytes 14 to 19 zero. A response frame (`rsp_req`) copies bytes 4 to 13 of the last accepted plain command frame into bytes 4 to 13.
- R9: Every delivered frame pulses `irq_d2h`. `irq_tfe` pulses with it when `dev_status` bit 0 is set.
- R10: While `fis_rx_en` is low a request produces no `tx_valid`, `irq_d2h` or `irq_tfe`.
- R11: An initial frame (`init_req`, which wins over `rsp_req`) has byte 4 = 1 and byte 12 = 1. When `atapi_dev` is set, bytes 5 and 6 hold `sig_cyl_lo` and `sig_cyl_hi`. All other payload bytes are zero.
- R12: After reset all pulse outputs are low, the tracker is running, and the echo bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Inbound frame present this cycle |
| rx_frame | input | 160 | Inbound frame, byte n at bits 8n+7:8n |
| cmd_valid | output | 1 | Plain command decoded |
| cmd_opcode | output | 8 | Command opcode |
| cmd_feature | output | 8 | Feature byte |
| cmd_count | output | 16 | Block count, zero mapped to 256 |
| cmd_lba | output | 48 | Merged block address |
| q_valid | output | 1 | Queued command decoded |
| q_write | output | 1 | Queued command is a write |
| q_tag | output | 5 | Queued command tag |
| q_lba | output | 48 | Queued command block address |
| frame_err | output | 1 | Inbound frame rejected |
| port_rst | output | 1 | Port reset request on soft-reset release |
| rsp_req | input | 1 | Build a response frame |
| init_req | input | 1 | Build the initial frame |
| fis_rx_en | input | 1 | Frame reception enabled |
| dev_status | input | 8 | Device status byte |
| dev_error | input | 8 | Device error byte |
| host_irq_pend | input | 1 | Any host interrupt pending |
| atapi_dev | input | 1 | Attached device is a packet device |
| sig_cyl_lo | input | 8 | Signature low cylinder byte |
| sig_cyl_hi | input | 8 | Signature high cylinder byte |
| tx_valid | output | 1 | Outbound frame valid |
| tx_frame | output | 160 | Outbound frame, byte n at bits 8n+7:8n |
| irq_d2h | output | 1 | Register-frame interrupt cause |
| irq_tfe | output | 1 | Task-file-error interrupt cause |

## Verification
The bench sends a block address whose nibble in byte 7 overlaps byte 8. A decoder that selects one address form instead of merging both would lose bits 27:24. The same nibble is placed in a queued frame, where a design that merged it would corrupt `q_lba`. A zero count checks that a design passing the raw value, or widening it to 65536, is caught. Tag 31 checks that the tag shift keeps the top bit. The soft-reset sequence includes a rejected frame while the tracker is held, which would give a spurious port reset in a tracker that looks at unaccepted frames. A repeated set bit must not pulse. The encoder checks cover a pending host interrupt, an error status that must add the task-file cause, disabled reception that must stay silent, and the packet-device signature bytes in the initial frame.

// File: rtl/sata_fis_pkg.sv
package sata_fis_pkg;
   localparam int unsigned LBA_W    = 48;
   localparam int unsigned ECHO_LO  = 4;
   localparam int unsigned ECHO_NB  = 10;
   localparam logic [7:0]  FT_H2D   = 8'h27;
   localparam logic [7:0]  FT_D2H   = 8'h34;

   typedef enum logic {
      SRST_RUN  = 1'b0,
      SRST_HELD = 1'b1
   } srst_state_e;

   typedef enum logic [1:0] {
      FK_DROP   = 2'd0,
      FK_CTRL   = 2'd1,
      FK_CMD    = 2'd2,
      FK_QUEUED = 2'd3
   } frame_kind_e;
endpackage

// File: rtl/regfis_parse.sv
module regfis_parse
   import sata_fis_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 20,
   parameter logic [7:0]  QRD_OP      = 8'h60,
   parameter logic [7:0]  QWR_OP      = 8'h61,
   parameter logic [7:0]  CUPD        = 8'h80,
   parameter int unsigned SRST_BIT    = 2,
   parameter int unsigned TAG_SHIFT   = 3,
   localparam int unsigned FRAME_W    = FRAME_BYTES * 8,
   localparam int unsigned ECHO_W     = ECHO_NB * 8,
   localparam int unsigned TAG_W      = 8 - TAG_SHIFT,
   localparam int unsigned CNT_W      = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [FRAME_W-1:0]   in_frame,
   output logic                 accept_o,
   output logic                 srst_bit_o,
   output logic                 cmd_valid_o,
   output logic [7:0]           cmd_op_o,
   output logic [7:0]           cmd_feat_o,
   output logic [CNT_W-1:0]     cmd_count_o,
   output logic [LBA_W-1:0]     cmd_lba_o,
   output logic                 q_valid_o,
   output logic                 q_write_o,
   output logic [TAG_W-1:0]     q_tag_o,
   output logic [LBA_W-1:0]     q_lba_o,
   output logic                 err_o,
   output logic [ECHO_W-1:0]    echo_o
);

   if (FRAME_BYTES < 20) begin : g_bad_frame
      $error("regfis_parse: FRAME_BYTES must be at least 20");
   end
   if (SRST_BIT > 7 || TAG_SHIFT > 7) begin : g_bad_bits
      $error("regfis_parse: bit position out of byte range");
   end

   logic [7:0] byt [FRAME_BYTES];
   for (genvar gi = 0; gi < FRAME_BYTES; gi++) begin : g_split
      assign byt[gi] = in_frame[8*gi +: 8];
   end

   frame_kind_e kind;
   logic        type_ok;
   logic        ctl_ok;
   logic        is_queued;

   always_comb begin
      type_ok   = (byt[0] == FT_H2D);
      ctl_ok    = (byt[1] == CUPD) || (byt[1] == 8'h00);
      is_queued = (byt[2] == QRD_OP) || (byt[2] == QWR_OP);
      if (!type_ok || !ctl_ok)  kind = FK_DROP;
      else if (byt[1] == 8'h00) kind = FK_CTRL;
      else if (is_queued)       kind = FK_QUEUED;
      else                      kind = FK_CMD;
   end

   assign accept_o   = in_valid && (kind != FK_DROP);
   assign srst_bit_o = byt[15][SRST_BIT];

   logic [CNT_W-1:0] raw_cnt;
   logic [CNT_W-1:0] cnt_fix;
   logic [LBA_W-1:0] lba_wide;
   logic [LBA_W-1:0] lba_merge;

   always_comb begin
      raw_cnt   = {byt[13], byt[12]};
      cnt_fix   = (raw_cnt == '0) ? CNT_W'(256) : raw_cnt;
      lba_wide  = {byt[10], byt[9], byt[8], byt[6], byt[5], byt[4]};
      lba_merge = lba_wide | (LBA_W'(byt[7][3:0]) << 24);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid_o <= 1'b0;
         cmd_op_o    <= '0;
         cmd_feat_o  <= '0;
         cmd_count_o <= '0;
         cmd_lba_o   <= '0;
         q_valid_o   <= 1'b0;
         q_write_o   <= 1'b0;
         q_tag_o     <= '0;
         q_lba_o     <= '0;
         err_o       <= 1'b0;
         echo_o      <= '0;
      end else begin
         cmd_valid_o <= in_valid && (kind == FK_CMD);
         q_valid_o   <= in_valid && (kind == FK_QUEUED);
         err_o       <= in_valid && (kind == FK_DROP);
         if (in_valid && kind == FK_CMD) begin
            cmd_op_o    <= byt[2];
            cmd_feat_o  <= byt[3];
            cmd_count_o <= cnt_fix;
            cmd_lba_o   <= lba_merge;
            echo_o      <= in_frame[8*ECHO_LO +: ECHO_W];
         end
         if (in_valid && kind == FK_QUEUED) begin
            q_write_o <= (byt[2] == QWR_OP);
            q_tag_o   <= byt[12][7:TAG_SHIFT];
            q_lba_o   <= lba_wide;
         end
      end
   end

endmodule

// File: rtl/srst_track.sv
module srst_track
   import sata_fis_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_ok,
   input  logic        srst_bit,
   output logic        port_rst_o,
   output srst_state_e state_o
);

   srst_state_e st_nx;
   logic        rel_nx;

   always_comb begin
      st_nx  = state_o;
      rel_nx = 1'b0;
      if (frame_ok) begin
         unique case (state_o)
            SRST_RUN:  if (srst_bit)  st_nx = SRST_HELD;
            SRST_HELD: if (!srst_bit) begin
               st_nx  = SRST_RUN;
               rel_nx = 1'b1;
            end
            default:   st_nx = SRST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o    <= SRST_RUN;
         port_rst_o <= 1'b0;
      end else begin
         state_o    <= st_nx;
         port_rst_o <= rel_nx;
      end
   end

endmodule

// File: rtl/d2h_build.sv
module d2h_build
   import sata_fis_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 20,
   parameter int unsigned ERR_BIT     = 0,
   parameter int unsigned IRQ_BIT     = 6,
   localparam int unsigned FRAME_W    = FRAME_BYTES * 8,
   localparam int unsigned ECHO_W     = ECHO_NB * 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rsp_req,
   input  logic               init_req,
   input  logic               rx_en,
   input  logic [7:0]         status,
   input  logic [7:0]         error,
   input  logic               irq_pend,
   input  logic               atapi,
   input  logic [7:0]         sig_lo,
   input  logic [7:0]         sig_hi,
   input  logic [ECHO_W-1:0]  echo,
   output logic               tx_valid_o,
   output logic [FRAME_W-1:0] tx_frame_o,
   output logic               irq_d2h_o,
   output logic               irq_tfe_o
);

   if (FRAME_BYTES < 20) begin : g_bad_frame
      $error("d2h_build: FRAME_BYTES must be at least 20");
   end
   if (ERR_BIT > 7 || IRQ_BIT > 7) begin : g_bad_bits
      $error("d2h_build: bit position out of byte range");
   end

   logic [7:0] init_pl [ECHO_NB];
   for (genvar gi = 0; gi < ECHO_NB; gi++) begin : g_init
      if (gi == 0 || gi == 8) begin : g_one
         assign init_pl[gi] = 8'h01;
      end else if (gi == 1) begin : g_lo
         assign init_pl[gi] = atapi ? sig_lo : 8'h00;
      end else if (gi == 2) begin : g_hi
         assign init_pl[gi] = atapi ? sig_hi : 8'h00;
      end else begin : g_zero
         assign init_pl[gi] = 8'h00;
      end
   end

   logic               fire;
   logic [7:0]         hdr1;
   logic [ECHO_W-1:0]  payload;
   logic [FRAME_W-1:0] frame_nx;

   always_comb begin
      fire          = (rsp_req || init_req) && rx_en;
      hdr1          = '0;
      hdr1[IRQ_BIT] = irq_pend;
      for (int k = 0; k < ECHO_NB; k++) begin
         payload[8*k +: 8] = init_req ? init_pl[k] : echo[8*k +: 8];
      end
      frame_nx                    = '0;
      frame_nx[7:0]               = FT_D2H;
      frame_nx[15:8]              = hdr1;
      frame_nx[23:16]             = status;
      frame_nx[31:24]             = error;
      frame_nx[8*ECHO_LO +: ECHO_W] = payload;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid_o <= 1'b0;
         tx_frame_o <= '0;
         irq_d2h_o  <= 1'b0;
         irq_tfe_o  <= 1'b0;
      end else begin
         tx_valid_o <= fire;
         irq_d2h_o  <= fire;
         irq_tfe_o  <= fire && status[ERR_BIT];
         if (fire) tx_frame_o <= frame_nx;
      end
   end

endmodule

// File: rtl/regfis_codec.sv
module regfis_codec
   import sata_fis_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 20,
   parameter logic [7:0]  QRD_OP      = 8'h60,
   parameter logic [7:0]  QWR_OP      = 8'h61,
   parameter int unsigned SRST_BIT    = 2,
   parameter int unsigned ERR_BIT     = 0,
   parameter int unsigned IRQ_BIT     = 6,
   localparam int unsigned FRAME_W    = FRAME_BYTES * 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [FRAME_W-1:0] rx_frame,
   output logic               cmd_valid,
   output logic [7:0]         cmd_opcode,
   output logic [7:0]         cmd_feature,
   output logic [15:0]        cmd_count,
   output logic [47:0]        cmd_lba,
   output logic               q_valid,
   output logic               q_write,
   output logic [4:0]         q_tag,
   output logic [47:0]        q_lba,
   output logic               frame_err,
   output logic               port_rst,
   input  logic               rsp_req,
   input  logic               init_req,
   input  logic               fis_rx_en,
   input  logic [7:0]         dev_status,
   input  logic [7:0]         dev_error,
   input  logic               host_irq_pend,
   input  logic               atapi_dev,
   input  logic [7:0]         sig_cyl_lo,
   input  logic [7:0]         sig_cyl_hi,
   output logic               tx_valid,
   output logic [FRAME_W-1:0] tx_frame,
   output logic               irq_d2h,
   output logic               irq_tfe
);

   logic              accept;
   logic              srst_bit;
   logic [8*ECHO_NB-1:0] echo;
   srst_state_e       trk_state;

   regfis_parse #(
      .FRAME_BYTES (FRAME_BYTES),
      .QRD_OP      (QRD_OP),
      .QWR_OP      (QWR_OP),
      .CUPD        (8'h80),
      .SRST_BIT    (SRST_BIT),
      .TAG_SHIFT   (3)
   ) i_parse (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (rx_valid),
      .in_frame    (rx_frame),
      .accept_o    (accept),
      .srst_bit_o  (srst_bit),
      .cmd_valid_o (cmd_valid),
      .cmd_op_o    (cmd_opcode),
      .cmd_feat_o  (cmd_feature),
      .cmd_count_o (cmd_count),
      .cmd_lba_o   (cmd_lba),
      .q_valid_o   (q_valid),
      .q_write_o   (q_write),
      .q_tag_o     (q_tag),
      .q_lba_o     (q_lba),
      .err_o       (frame_err),
      .echo_o      (echo)
   );

   srst_track i_srst (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_ok   (accept),
      .srst_bit   (srst_bit),
      .port_rst_o (port_rst),
      .state_o    (trk_state)
   );

   d2h_build #(
      .FRAME_BYTES (FRAME_BYTES),
      .ERR_BIT     (ERR_BIT),
      .IRQ_BIT     (IRQ_BIT)
   ) i_build (
      .clk        (clk),
      .rst_n      (rst_n),
      .rsp_req    (rsp_req),
      .init_req   (init_req),
      .rx_en      (fis_rx_en),
      .status     (dev_status),
      .error      (dev_error),
      .irq_pend   (host_irq_pend),
      .atapi      (atapi_dev),
      .sig_lo     (sig_cyl_lo),
      .sig_hi     (sig_cyl_hi),
      .echo       (echo),
      .tx_valid_o (tx_valid),
      .tx_frame_o (tx_frame),
      .irq_d2h_o  (irq_d2h),
      .irq_tfe_o  (irq_tfe)
   );

endmodule

// File: rtl/regfis_codec_chk.sv
module regfis_codec_chk #(
   parameter int unsigned FRAME_W = 160,
   parameter int unsigned ERR_BIT = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rx_valid,
   input logic               cmd_valid,
   input logic [15:0]        cmd_count,
   input logic               q_valid,
   input logic               frame_err,
   input logic               port_rst,
   input logic               fis_rx_en,
   input logic               tx_valid,
   input logic [FRAME_W-1:0] tx_frame,
   input logic               irq_d2h,
   input logic               irq_tfe
);

   a_r3_cmd_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(rx_valid));

   a_r1_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> (!cmd_valid && !q_valid));

   a_r6_queued_alone: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> !cmd_valid);

   a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_count != 16'd0));

   a_r7_rst_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst |-> $past(rx_valid));

   a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(fis_rx_en));

   a_r9_tfe_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tfe |-> (irq_d2h && tx_frame[16 + ERR_BIT]));

   a_r8_frame_shape: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_frame[7:0] == 8'h34 && tx_frame[159:112] == '0));

endmodule

bind regfis_codec regfis_codec_chk #(
   .FRAME_W (FRAME_W),
   .ERR_BIT (ERR_BIT)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .cmd_valid (cmd_valid),
   .cmd_count (cmd_count),
   .q_valid   (q_valid),
   .frame_err (frame_err),
   .port_rst  (port_rst),
   .fis_rx_en (fis_rx_en),
   .tx_valid  (tx_valid),
   .tx_frame  (tx_frame),
   .irq_d2h   (irq_d2h),
   .irq_tfe   (irq_tfe)
);

// File: tb/test_regfis_codec.sv
`timescale 1ns/1ps
module test_regfis_codec;

   function automatic logic [159:0] mkf(
      input logic [7:0] t, c, op, ft, l0, l1, l2, d7, l3, l4, l5, cl, ch, ctl);
      logic [159:0] f;
      f = '0;
      f[7:0] = t;     f[15:8] = c;    f[23:16] = op;  f[31:24] = ft;
      f[39:32] = l0;  f[47:40] = l1;  f[55:48] = l2;  f[63:56] = d7;
      f[71:64] = l3;  f[79:72] = l4;  f[87:80] = l5;
      f[103:96] = cl; f[111:104] = ch; f[127:120] = ctl;
      return f;
   endfunction

   function automatic logic [159:0] mkrsp(
      input logic pend, input logic [7:0] st, er, input logic [79:0] pl);
      logic [159:0] f;
      f = '0;
      f[7:0] = 8'h34; f[14] = pend; f[23:16] = st; f[31:24] = er;
      f[111:32] = pl;
      return f;
   endfunction

   localparam int NV = 8;
   localparam logic [159:0] VF [NV] = '{
      mkf(8'h27,8'h80,8'h25,8'h00,8'h11,8'h22,8'h33,8'h00,8'h44,8'h55,8'h66,8'h08,8'h00,8'h00),
      mkf(8'h27,8'h80,8'hC8,8'h05,8'h78,8'h56,8'h34,8'hE9,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00),
      mkf(8'h27,8'h80,8'h35,8'h00,8'h01,8'h02,8'h03,8'h05,8'h0A,8'h00,8'h00,8'h02,8'h01,8'h00),
      mkf(8'h27,8'h80,8'h60,8'h10,8'h01,8'h02,8'h03,8'h40,8'h04,8'h05,8'h06,8'h28,8'h00,8'h00),
      mkf(8'h27,8'h80,8'h61,8'h00,8'hAA,8'hAA,8'hAA,8'h0F,8'hAA,8'hAA,8'hAA,8'hF8,8'h00,8'h00),
      mkf(8'h34,8'h80,8'h25,8'h00,8'h11,8'h22,8'h33,8'h00,8'h44,8'h55,8'h66,8'h08,8'h00,8'h00),
      mkf(8'h27,8'h40,8'h25,8'h00,8'h11,8'h22,8'h33,8'h00,8'h44,8'h55,8'h66,8'h08,8'h00,8'h00),
      mkf(8'h27,8'h00,8'h25,8'h00,8'h11,8'h22,8'h33,8'h00,8'h44,8'h55,8'h66,8'h08,8'h00,8'h00)
   };
   // kind: 0 rejected, 1 control only, 2 plain command, 3 queued
   localparam int           VK [NV] = '{2, 2, 2, 3, 3, 0, 0, 1};
   localparam logic [7:0]   VO [NV] = '{8'h25, 8'hC8, 8'h35, 8'h60, 8'h61, 0, 0, 0};
   localparam logic [7:0]   VFT[NV] = '{8'h00, 8'h05, 8'h00, 0, 0, 0, 0, 0};
   localparam logic [15:0]  VC [NV] = '{16'd8, 16'd256, 16'h0102, 0, 0, 0, 0, 0};
   localparam logic [47:0]  VL [NV] = '{48'h6655_4433_2211, 48'h0000_0934_5678,
      48'h0000_0F03_0201, 48'h0605_0403_0201, 48'hAAAA_AAAA_AAAA, 0, 0, 0};
   localparam logic [4:0]   VT [NV] = '{0, 0, 0, 5'd5, 5'd31, 0, 0, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [159:0] rx_frame = '0;
   logic rsp_req = 1'b0, init_req = 1'b0, fis_rx_en = 1'b0;
   logic [7:0] dev_status = '0, dev_error = '0;
   logic host_irq_pend = 1'b0, atapi_dev = 1'b0;
   logic [7:0] sig_cyl_lo = 8'h14, sig_cyl_hi = 8'hEB;
   logic cmd_valid, q_valid, q_write, frame_err, port_rst, tx_valid, irq_d2h, irq_tfe;
   logic [7:0] cmd_opcode, cmd_feature;
   logic [15:0] cmd_count;
   logic [47:0] cmd_lba, q_lba;
   logic [4:0] q_tag;
   logic [159:0] tx_frame;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   regfis_codec i_regfis_codec (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_frame(rx_frame),
      .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_feature(cmd_feature),
      .cmd_count(cmd_count), .cmd_lba(cmd_lba), .q_valid(q_valid), .q_write(q_write),
      .q_tag(q_tag), .q_lba(q_lba), .frame_err(frame_err), .port_rst(port_rst),
      .rsp_req(rsp_req), .init_req(init_req), .fis_rx_en(fis_rx_en),
      .dev_status(dev_status), .dev_error(dev_error), .host_irq_pend(host_irq_pend),
      .atapi_dev(atapi_dev), .sig_cyl_lo(sig_cyl_lo), .sig_cyl_hi(sig_cyl_hi),
      .tx_valid(tx_valid), .tx_frame(tx_frame), .irq_d2h(irq_d2h), .irq_tfe(irq_tfe));

   task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [159:0] f);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_frame = f;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic request(input logic rsp, input logic ini);
      @(negedge clk);
      rsp_req  = rsp;
      init_req = ini;
      @(negedge clk);
      rsp_req  = 1'b0;
      init_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 pulses idle", {cmd_valid, q_valid, frame_err, port_rst, tx_valid, irq_d2h, irq_tfe}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 idle after release", {cmd_valid, q_valid, frame_err, port_rst, tx_valid}, '0);

      // R12 echo bytes zero: response right after reset
      fis_rx_en = 1'b1;
      request(1'b1, 1'b0);
      check("R12 R8 echo zero after reset", tx_frame, mkrsp(1'b0, 8'h00, 8'h00, 80'h0));

      for (int i = 0; i < NV; i++) begin
         send(VF[i]);
         check($sformatf("R1 R2 v%0d frame_err", i), frame_err, VK[i] == 0);
         check($sformatf("R2 R3 v%0d cmd_valid", i), cmd_valid, VK[i] == 2);
         check($sformatf("R6 v%0d q_valid", i), q_valid, VK[i] == 3);
         check($sformatf("R7 v%0d no port_rst", i), port_rst, 1'b0);
         if (VK[i] == 2) begin
            check($sformatf("R3 v%0d opcode", i), cmd_opcode, VO[i]);
            check($sformatf("R3 v%0d feature", i), cmd_feature, VFT[i]);
            check($sformatf("R4 v%0d count", i), cmd_count, VC[i]);
            check($sformatf("R5 v%0d lba", i), cmd_lba, VL[i]);
         end
         if (VK[i] == 3) begin
            check($sformatf("R6 v%0d tag", i), q_tag, VT[i]);
            check($sformatf("R6 v%0d lba", i), q_lba, VL[i]);
            check($sformatf("R6 v%0d write", i), q_write, VO[i] == 8'h61);
         end
      end

      // R7 soft-reset tracker
      send(mkf(8'h27,8'h00,0,0,0,0,0,0,0,0,0,0,0,8'h04));
      check("R7 set bit no pulse", port_rst, 1'b0);
      send(mkf(8'h27,8'h00,0,0,0,0,0,0,0,0,0,0,0,8'h04));
      check("R7 repeated set no pulse", port_rst, 1'b0);
      send(mkf(8'h55,8'h00,0,0,0,0,0,0,0,0,0,0,0,8'h00));
      check("R1 rejected frame leaves tracker", port_rst, 1'b0);
      check("R1 rejected frame flagged", frame_err, 1'b1);
      send(mkf(8'h27,8'h00,0,0,0,0,0,0,0,0,0,0,0,8'h00));
      check("R7 release pulses port_rst", port_rst, 1'b1);
      @(negedge clk);
      check("R7 pulse one cycle", port_rst, 1'b0);
      send(mkf(8'h27,8'h00,0,0,0,0,0,0,0,0,0,0,0,8'h00));
      check("R7 running clear bit no pulse", port_rst, 1'b0);

      // R8 R9 response frames
      send(VF[0]);
      dev_status = 8'h50; dev_error = 8'h00; host_irq_pend = 1'b1;
      request(1'b1, 1'b0);
      check("R8 response frame", tx_frame,
            mkrsp(1'b1, 8'h50, 8'h00, 80'h00_08_00_66_55_44_00_33_22_11));
      check("R9 d2h cause", {tx_valid, irq_d2h, irq_tfe}, 3'b110);
      dev_status = 8'h51; dev_error = 8'h04; host_irq_pend = 1'b0;
      request(1'b1, 1'b0);
      check("R8 response with error", tx_frame,
            mkrsp(1'b0, 8'h51, 8'h04, 80'h00_08_00_66_55_44_00_33_22_11));
      check("R9 tfe cause", {tx_valid, irq_d2h, irq_tfe}, 3'b111);

      // R10 disabled reception
      fis_rx_en = 1'b0;
      request(1'b1, 1'b0);
      check("R10 no frame when disabled", {tx_valid, irq_d2h, irq_tfe}, 3'b000);
      request(1'b0, 1'b1);
      check("R10 no initial frame when disabled", {tx_valid, irq_d2h, irq_tfe}, 3'b000);
      check("R10 frame contents kept", tx_frame,
            mkrsp(1'b0, 8'h51, 8'h04, 80'h00_08_00_66_55_44_00_33_22_11));

      // R11 initial frames
      fis_rx_en = 1'b1;
      dev_status = 8'h50; dev_error = 8'h01;
      request(1'b1, 1'b1);
      check("R11 initial frame disk", tx_frame,
            mkrsp(1'b0, 8'h50, 8'h01, 80'h00_01_00_00_00_00_00_00_00_01));
      atapi_dev = 1'b1;
      request(1'b0, 1'b1);
      check("R11 initial frame packet device", tx_frame,
            mkrsp(1'b0, 8'h50, 8'h01, 80'h00_01_00_00_00_00_00_EB_14_01));
      check("R9 initial frame cause", {tx_valid, irq_d2h, irq_tfe}, 3'b110);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule